// File: doc/BRIEF.md
# Counting Trigger Sequencer

This block turns the hit outputs of a bank of pattern match units into one trigger pulse. The trigger fires only after a programmed series of events has happened in a fixed order, with each event seen a programmed number of times. The block holds several sequencers of four stages each. A stage builds a term from a masked subset of the match inputs, combined by AND or by OR. It counts the valid samples on which that term is true, and it hands over to the next stage when the count reaches the stage's threshold.

When the last stage of a sequencer completes, the first stage of the next sequencer becomes active. Software picks which sequencer closes the chain. Completing that sequencer raises the trigger for one clock and returns the block to idle. The block stays idle until it is armed again. Capture storage sits outside this block.

The configuration for stage `s` of sequencer `q` sits at flat index `i = q*4 + s` in every configuration bus.

Top module: `trig_seq_top`

## Requirements
- R1: After reset, `busy` and `trigger` are 0 and `cur_seq` and `cur_stage` are both 0.
- R2: A cycle with `arm` high sets `busy` and returns to sequencer 0, stage 0 with the occurrence count cleared. This also applies while a run is in progress. A sample presented in the same cycle as `arm` is not counted.
- R3: When `cfg_mode[i]` is 0 (AND), the term is true when every match input selected by mask bits `cfg_mask[i*M +: M]` is 1. An all-zero mask makes the term always true.
- R4: When `cfg_mode[i]` is 1 (OR), the term is true when any selected match input is 1. An all-zero mask makes the term never true.
- R5: Cycles with `sample_valid` low change no state. While idle, no input other than `arm` changes any state.
- R6: A stage advances on the valid sample that makes the number of true-term samples equal `cfg_count[i*CW +: CW]`. The counted samples need not be consecutive. The count restarts at zero in each new stage.
- R7: A stage count of 0 or 1 advances on the first occurrence.
- R8: Stages run 0, 1, 2, 3 in order, and then move on to stage 0 of the next sequencer. `cur_seq` and `cur_stage` show the active position.
- R9: In the cycle after the valid sample that completes stage 3 of sequencer `cfg_last_seq`, `trigger` is 1 for exactly one clock. In that same cycle `busy` drops to 0 and the position returns to 0/0. After that the block ignores samples until it is armed again.
- R10: Sequencers with an index above `cfg_last_seq` are never entered, and their configuration has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start or restart a run |
| sample_valid | input | 1 | The match vector in this cycle is a sample |
| match_in | input | NUM_MATCH | Hit flags from the match units |
| cfg_mask | input | NUM_SEQ*4*NUM_MATCH | Per-stage mask of match inputs |
| cfg_mode | input | NUM_SEQ*4 | Per-stage combine: 0 AND, 1 OR |
| cfg_count | input | NUM_SEQ*4*CNT_W | Per-stage occurrence threshold |
| cfg_last_seq | input | SEQ_W | Sequencer whose completion fires the trigger |
| trigger | output | 1 | One-clock trigger pulse |
| busy | output | 1 | A run is in progress |
| cur_seq | output | SEQ_W | Active sequencer |
| cur_stage | output | 2 | Active stage inside the sequencer |

## Verification
The assertions check the following on every cycle:
- the trigger is one clock wide and only coincides with idle;
- arming lands at 0/0 with the count cleared;
- invalid samples and the idle state leave the position and count frozen;
- the occurrence count only holds, steps by one, or clears.

Only the bench scenarios can show the rest:
- that the threshold is reached on exactly the Nth non-consecutive hit;
- how AND and OR terms behave, including empty masks;
- that the chain crosses into the next sequencer;
- that the trigger fires after the sequencer chosen by `cfg_last_seq` and no other.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
    localparam int unsigned STAGES_PER_SEQ = 4;
    localparam int unsigned STAGE_W        = 2;

    typedef enum logic {
        COMB_AND = 1'b0,
        COMB_OR  = 1'b1
    } comb_e;
endpackage

// File: rtl/trig_cfg_select.sv
module trig_cfg_select
    import trig_seq_pkg::*;
#(
    parameter int unsigned NUM_SEQ   = 4,
    parameter int unsigned NUM_MATCH = 8,
    parameter int unsigned CNT_W     = 16,
    localparam int unsigned SEQ_W    = $clog2(NUM_SEQ),
    localparam int unsigned NSTG     = NUM_SEQ * STAGES_PER_SEQ,
    localparam int unsigned IDX_W    = SEQ_W + STAGE_W
) (
    input  logic [NSTG*NUM_MATCH-1:0] cfg_mask,
    input  logic [NSTG-1:0]           cfg_mode,
    input  logic [NSTG*CNT_W-1:0]     cfg_count,
    input  logic [SEQ_W-1:0]          seq,
    input  logic [STAGE_W-1:0]        stage,
    output logic [NUM_MATCH-1:0]      sel_mask,
    output comb_e                     sel_mode,
    output logic [CNT_W-1:0]          sel_thr
);
    logic [NUM_MATCH-1:0] mask_arr [NSTG];
    logic [CNT_W-1:0]     cnt_arr  [NSTG];
    logic [IDX_W-1:0]     idx;

    for (genvar g = 0; g < NSTG; g++) begin : g_unpack
        assign mask_arr[g] = cfg_mask[g*NUM_MATCH +: NUM_MATCH];
        assign cnt_arr[g]  = cfg_count[g*CNT_W +: CNT_W];
    end

    assign idx      = {seq, stage};
    assign sel_mask = mask_arr[idx];
    assign sel_mode = comb_e'(cfg_mode[idx]);
    // A programmed count of zero is treated as one.
    assign sel_thr  = (cnt_arr[idx] == '0) ? CNT_W'(1) : cnt_arr[idx];
endmodule

// File: rtl/trig_term_eval.sv
module trig_term_eval
    import trig_seq_pkg::*;
#(
    parameter int unsigned NUM_MATCH = 8
) (
    input  logic [NUM_MATCH-1:0] match_in,
    input  logic [NUM_MATCH-1:0] mask,
    input  comb_e                mode,
    output logic                 hit
);
    logic [NUM_MATCH-1:0] sel;

    always_comb begin
        sel = match_in & mask;
        if (mode == COMB_OR) hit = |sel;
        else                 hit = (sel == mask);
    end
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top
    import trig_seq_pkg::*;
#(
    parameter int unsigned NUM_SEQ   = 4,
    parameter int unsigned NUM_MATCH = 8,
    parameter int unsigned CNT_W     = 16,
    localparam int unsigned SEQ_W    = $clog2(NUM_SEQ),
    localparam int unsigned NSTG     = NUM_SEQ * STAGES_PER_SEQ
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arm,
    input  logic                      sample_valid,
    input  logic [NUM_MATCH-1:0]      match_in,
    input  logic [NSTG*NUM_MATCH-1:0] cfg_mask,
    input  logic [NSTG-1:0]           cfg_mode,
    input  logic [NSTG*CNT_W-1:0]     cfg_count,
    input  logic [SEQ_W-1:0]          cfg_last_seq,
    output logic                      trigger,
    output logic                      busy,
    output logic [SEQ_W-1:0]          cur_seq,
    output logic [STAGE_W-1:0]        cur_stage
);
    localparam logic [STAGE_W-1:0] LAST_STAGE = STAGE_W'(STAGES_PER_SEQ - 1);

    typedef struct packed {
        logic               busy;
        logic               trig;
        logic [SEQ_W-1:0]   seq;
        logic [STAGE_W-1:0] stage;
        logic [CNT_W-1:0]   cnt;
    } state_t;

    state_t               st_d, st_q;
    logic [NUM_MATCH-1:0] sel_mask;
    comb_e                sel_mode;
    logic [CNT_W-1:0]     sel_thr;
    logic                 term_hit;
    logic [CNT_W:0]       cnt_inc;

    trig_cfg_select #(
        .NUM_SEQ   (NUM_SEQ),
        .NUM_MATCH (NUM_MATCH),
        .CNT_W     (CNT_W)
    ) u_cfg_sel (
        .cfg_mask  (cfg_mask),
        .cfg_mode  (cfg_mode),
        .cfg_count (cfg_count),
        .seq       (st_q.seq),
        .stage     (st_q.stage),
        .sel_mask  (sel_mask),
        .sel_mode  (sel_mode),
        .sel_thr   (sel_thr)
    );

    trig_term_eval #(
        .NUM_MATCH (NUM_MATCH)
    ) u_term (
        .match_in (match_in),
        .mask     (sel_mask),
        .mode     (sel_mode),
        .hit      (term_hit)
    );

    assign cnt_inc = {1'b0, st_q.cnt} + (CNT_W+1)'(1);

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        if (arm) begin
            st_d.busy  = 1'b1;
            st_d.seq   = '0;
            st_d.stage = '0;
            st_d.cnt   = '0;
        end else if (st_q.busy && sample_valid && term_hit) begin
            if (cnt_inc >= {1'b0, sel_thr}) begin
                st_d.cnt = '0;
                if (st_q.stage == LAST_STAGE) begin
                    st_d.stage = '0;
                    if (st_q.seq == cfg_last_seq) begin
                        st_d.busy = 1'b0;
                        st_d.trig = 1'b1;
                        st_d.seq  = '0;
                    end else begin
                        st_d.seq = st_q.seq + SEQ_W'(1);
                    end
                end else begin
                    st_d.stage = st_q.stage + STAGE_W'(1);
                end
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trigger   = st_q.trig;
    assign busy      = st_q.busy;
    assign cur_seq   = st_q.seq;
    assign cur_stage = st_q.stage;

    assert_trig_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> !trigger);

    assert_trig_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |-> (!busy && cur_seq == '0 && cur_stage == '0));

    assert_arm_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (busy && cur_seq == '0 && cur_stage == '0 && st_q.cnt == '0));

    assert_invalid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sample_valid && !arm) |=>
            ($stable(cur_seq) && $stable(cur_stage) && $stable(st_q.cnt) && busy));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !arm) |=> (!busy && !trigger && $stable(cur_stage) && $stable(cur_seq)));

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (st_q.cnt == '0 || st_q.cnt == $past(st_q.cnt)
                  || st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));
endmodule

// File: tb/trig_seq_top_tb.sv
module trig_seq_top_tb;
    localparam int NS = 4, M = 8, CW = 16, SW = 2, NSTG = NS * 4;

    logic                 clk = 1'b0, rst_n = 1'b0, arm = 1'b0, sample_valid = 1'b0;
    logic [M-1:0]         match_in = '0;
    logic [NSTG*M-1:0]    cfg_mask = '0;
    logic [NSTG-1:0]      cfg_mode = '0;
    logic [NSTG*CW-1:0]   cfg_count = '0;
    logic [SW-1:0]        cfg_last_seq = '0;
    logic                 trigger, busy;
    logic [SW-1:0]        cur_seq;
    logic [1:0]           cur_stage;
    int                   n_tests = 0, n_fail = 0;
    bit                   done = 0;

    always #5 clk = ~clk;

    trig_seq_top #(.NUM_SEQ(NS), .NUM_MATCH(M), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .sample_valid(sample_valid),
        .match_in(match_in), .cfg_mask(cfg_mask), .cfg_mode(cfg_mode),
        .cfg_count(cfg_count), .cfg_last_seq(cfg_last_seq),
        .trigger(trigger), .busy(busy), .cur_seq(cur_seq), .cur_stage(cur_stage));

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_pos(input string tag, input int tr, input int bz, input int sq, input int sg);
        chk({tag, " trigger"}, int'(trigger), tr);
        chk({tag, " busy"}, int'(busy), bz);
        chk({tag, " seq"}, int'(cur_seq), sq);
        chk({tag, " stage"}, int'(cur_stage), sg);
    endtask

    task automatic set_stage(input int i, input logic [M-1:0] mk, input logic md, input int cnt);
        cfg_mask[i*M +: M]   = mk;
        cfg_mode[i]          = md;
        cfg_count[i*CW +: CW] = CW'(cnt);
    endtask

    task automatic set_all(input logic [M-1:0] mk, input logic md, input int cnt);
        for (int i = 0; i < NSTG; i++) set_stage(i, mk, md, cnt);
    endtask

    task automatic step(input logic v, input logic [M-1:0] m);
        @(negedge clk);
        arm = 1'b0; sample_valid = v; match_in = m;
        @(posedge clk); #1;
    endtask

    task automatic do_arm(input logic v, input logic [M-1:0] m);
        @(negedge clk);
        arm = 1'b1; sample_valid = v; match_in = m;
        @(posedge clk); #1;
        @(negedge clk);
        arm = 1'b0; sample_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk_pos("R1 reset", 0, 0, 0, 0);
    endtask

    task automatic t_basic;
        set_all(8'h01, 1'b0, 1);
        cfg_last_seq = 0;
        do_arm(1'b0, 8'h00);
        chk_pos("R2 arm", 0, 1, 0, 0);
        step(1'b0, 8'h01);
        chk_pos("R5 invalid", 0, 1, 0, 0);
        step(1'b1, 8'h01); chk_pos("R8 s1", 0, 1, 0, 1);
        step(1'b1, 8'h01); chk_pos("R8 s2", 0, 1, 0, 2);
        step(1'b1, 8'h01); chk_pos("R8 s3", 0, 1, 0, 3);
        step(1'b1, 8'h01); chk_pos("R9 fire", 1, 0, 0, 0);
        step(1'b1, 8'h01); chk_pos("R9 pulse end", 0, 0, 0, 0);
        step(1'b1, 8'h01); chk_pos("R9 idle", 0, 0, 0, 0);
    endtask

    task automatic t_count;
        set_all(8'h01, 1'b0, 0);
        set_stage(0, 8'h03, 1'b0, 5);
        do_arm(1'b0, 8'h00);
        for (int k = 0; k < 3; k++) step(1'b1, 8'h01);
        chk_pos("R3 partial AND", 0, 1, 0, 0);
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 8'h03);
            step(1'b0, 8'h03);
            step(1'b1, 8'h00);
        end
        chk_pos("R6 four hits", 0, 1, 0, 0);
        step(1'b1, 8'h07);
        chk_pos("R6 fifth hit", 0, 1, 0, 1);
        step(1'b1, 8'h01);
        chk_pos("R7 count zero", 0, 1, 0, 2);
        do_arm(1'b1, 8'h03);
        for (int k = 0; k < 4; k++) step(1'b1, 8'h03);
        chk_pos("R2 rearm clears count", 0, 1, 0, 0);
        step(1'b1, 8'h03);
        chk_pos("R2 rearm fifth", 0, 1, 0, 1);
    endtask

    task automatic t_or_empty;
        set_all(8'h01, 1'b0, 1);
        set_stage(0, 8'h0C, 1'b1, 1);
        set_stage(1, 8'h00, 1'b1, 1);
        set_stage(2, 8'h00, 1'b0, 3);
        do_arm(1'b0, 8'h00);
        step(1'b1, 8'hF3);
        chk_pos("R4 OR miss", 0, 1, 0, 0);
        step(1'b1, 8'h04);
        chk_pos("R4 OR hit", 0, 1, 0, 1);
        for (int k = 0; k < 3; k++) step(1'b1, 8'hFF);
        chk_pos("R4 OR empty never", 0, 1, 0, 1);
        do_arm(1'b0, 8'h00);
        chk_pos("R2 restart", 0, 1, 0, 0);
        step(1'b1, 8'h08);
        set_stage(1, 8'h01, 1'b0, 1);
        step(1'b1, 8'h01);
        chk_pos("R8 to s2", 0, 1, 0, 2);
        step(1'b1, 8'h00); step(1'b1, 8'h00);
        chk_pos("R3 empty AND two", 0, 1, 0, 2);
        step(1'b1, 8'h00);
        chk_pos("R3 empty AND three", 0, 1, 0, 3);
    endtask

    task automatic t_chain;
        set_all(8'h01, 1'b0, 1);
        for (int i = 8; i < NSTG; i++) set_stage(i, 8'h00, 1'b1, 1);
        cfg_last_seq = 1;
        do_arm(1'b0, 8'h00);
        for (int k = 0; k < 4; k++) step(1'b1, 8'h01);
        chk_pos("R8 next seq", 0, 1, 1, 0);
        for (int k = 0; k < 3; k++) step(1'b1, 8'h01);
        chk_pos("R10 seq1 s3", 0, 1, 1, 3);
        step(1'b1, 8'h01);
        chk_pos("R10 fire after last seq", 1, 0, 0, 0);
        step(1'b0, 8'h00);
        chk_pos("R9 single pulse", 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        @(negedge clk) rst_n = 1'b1;
        t_basic;
        t_count;
        t_or_empty;
        t_chain;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule